// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two unsigned operands of `WIDTH` bits (four by default) one bit per clock. It uses a single full adder, a carry flip-flop and two right-shifting registers. The accumulator register shifts each result bit back into its own top end, so at the end of a run it holds the sum. The addend register turns in a ring, so at the end of a run it again holds the value it started with. The carry flip-flop then holds the carry out of the top bit.

Operands are loaded in parallel while the block is idle. A start pulse in the idle state begins a run of exactly `WIDTH` shift clocks. The first shift happens on the same edge that leaves idle. The idle flag shows when the result can be read and when a new load or start will be accepted. If a run is started without a new load, the stored carry is used as carry-in, so several runs can be chained to accumulate. All pins are plain level controls. There is no handshake: a load or start that arrives while the block is busy is dropped.

Top module: `serial_accum_adder`

## Requirements
- R1: After synchronous reset, `idle_o` is 1 and `acc_o`, `addend_o` and `carry_o` are all zero.
- R2: While idle, `load_i`=1 copies `a_in` into the accumulator and `b_in` into the addend register on the next edge, clears the carry and leaves the block idle.
- R3: While idle, `start_i`=1 with `load_i`=0 starts a run of exactly `WIDTH` shift edges. `idle_o` is 0 for the `WIDTH`-1 cycles after the first edge and is 1 again after the last edge.
- R4: On every shift edge the accumulator moves right by one place, and the full-adder sum bit enters at its most significant bit.
- R5: On every shift edge the addend register rotates right (bit 0 re-enters at the top), so after a run it equals its value before the run.
- R6: The full adder takes bit 0 of both registers and the stored carry. The carry flip-flop takes the carry-out only on shift edges and holds while idle. A run that is not preceded by a load therefore gives {carry, acc} = acc + addend + carry.
- R7: After load and one run, {`carry_o`, `acc_o`} equals `a_in` + `b_in` for every operand pair.
- R8: `load_i` during a run is ignored: the run's result is unchanged.
- R9: `start_i` during a run is ignored: the run is neither lengthened nor restarted.
- R10: If `load_i` and `start_i` are both high in the same idle cycle, the load takes effect, no shift occurs and the block stays idle.
- R11: With 0101 loaded into the accumulator and 0111 into the addend, a run ends with an accumulator of 1100 and a carry of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a run (sampled only while idle) |
| load_i | input | 1 | Parallel load of both registers (sampled only while idle) |
| a_in | input | WIDTH | Accumulator load value |
| b_in | input | WIDTH | Addend load value |
| acc_o | output | WIDTH | Accumulator contents |
| addend_o | output | WIDTH | Addend register contents |
| carry_o | output | 1 | Carry flip-flop |
| idle_o | output | 1 | High when idle (run finished or never started) |

## Verification
Two events can fall in the same cycle here: a load and a start in one idle cycle, and a load or start arriving while a run is in progress. The bench raises both controls together in idle, then checks that the loaded values appear, that the carry is zero and that idle stays high. It also holds both controls high through entire runs, then checks that the run still takes exactly `WIDTH` edges and that the result still equals the sum of the operands loaded before the run.

// File: rtl/serial_accum_pkg.sv
package serial_accum_pkg;

  typedef struct packed {
    logic sum;
    logic cout;
  } fa_out_t;

  function automatic fa_out_t full_add(input logic a, input logic b, input logic cin);
    fa_out_t r;
    r.sum  = a ^ b ^ cin;
    r.cout = (a & b) | (a & cin) | (b & cin);
    return r;
  endfunction

endpackage

// File: rtl/sa_ctrl.sv
module sa_ctrl #(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic load_i,
  output logic shift_en,
  output logic load_en,
  output logic idle
);
  localparam int PW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(WIDTH - 1);

  logic [PW-1:0] phase_q, phase_d;

  assign idle     = (phase_q == '0);
  assign load_en  = idle & load_i;
  assign shift_en = idle ? (start_i & ~load_i) : 1'b1;

  always_comb begin
    if (idle) phase_d = shift_en ? PW'(1) : '0;
    else if (phase_q == LAST) phase_d = '0;
    else phase_d = phase_q + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else phase_q <= phase_d;
  end
endmodule

// File: rtl/sa_shreg.sv
module sa_shreg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] load_d,
  input  logic             serial_in,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (load_en) q <= load_d;
    else if (shift_en) q <= {serial_in, q[WIDTH-1:1]};
  end
endmodule

// File: rtl/sa_carry_stage.sv
module sa_carry_stage
  import serial_accum_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic shift_en,
  input  logic a_bit,
  input  logic b_bit,
  output logic sum_bit,
  output logic carry_q
);
  fa_out_t fa;

  assign fa      = full_add(a_bit, b_bit, carry_q);
  assign sum_bit = fa.sum;

  always_ff @(posedge clk) begin
    if (rst || clr) carry_q <= 1'b0;
    else if (shift_en) carry_q <= fa.cout;
  end
endmodule

// File: rtl/serial_accum_adder.sv
module serial_accum_adder #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] acc_o,
  output logic [WIDTH-1:0] addend_o,
  output logic             carry_o,
  output logic             idle_o
);
  logic shift_en, load_en, sum_bit;

  sa_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .load_i(load_i),
    .shift_en(shift_en), .load_en(load_en), .idle(idle_o)
  );

  sa_shreg #(.WIDTH(WIDTH)) u_acc (
    .clk(clk), .rst(rst), .load_en(load_en), .shift_en(shift_en),
    .load_d(a_in), .serial_in(sum_bit), .q(acc_o)
  );

  sa_shreg #(.WIDTH(WIDTH)) u_addend (
    .clk(clk), .rst(rst), .load_en(load_en), .shift_en(shift_en),
    .load_d(b_in), .serial_in(addend_o[0]), .q(addend_o)
  );

  sa_carry_stage u_carry (
    .clk(clk), .rst(rst), .clr(load_en), .shift_en(shift_en),
    .a_bit(acc_o[0]), .b_bit(addend_o[0]), .sum_bit(sum_bit), .carry_q(carry_o)
  );
endmodule

// File: rtl/serial_accum_adder_chk.sv
module serial_accum_adder_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             load_i,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] acc_o,
  input logic [WIDTH-1:0] addend_o,
  input logic             carry_o,
  input logic             idle_o
);
  logic [31:0] busy_cnt;
  logic        shifting;

  assign shifting = !idle_o || (start_i && !load_i);

  always_ff @(posedge clk) begin
    if (rst || idle_o) busy_cnt <= 32'd1;
    else busy_cnt <= busy_cnt + 32'd1;
  end

  a_r2_load_capture: assert property (@(posedge clk) disable iff (rst)
    (idle_o && load_i) |=> (acc_o == $past(a_in) && addend_o == $past(b_in) && !carry_o && idle_o));

  a_r3_run_ends: assert property (@(posedge clk) disable iff (rst)
    (!idle_o && busy_cnt == 32'(WIDTH - 1)) |=> idle_o);

  a_r3_no_overrun: assert property (@(posedge clk) disable iff (rst)
    !idle_o |-> (busy_cnt < 32'(WIDTH)));

  a_r4_acc_shift: assert property (@(posedge clk) disable iff (rst)
    shifting |=> (acc_o[WIDTH-2:0] == $past(acc_o[WIDTH-1:1]) &&
                  acc_o[WIDTH-1] == ($past(acc_o[0]) ^ $past(addend_o[0]) ^ $past(carry_o))));

  a_r5_addend_rotate: assert property (@(posedge clk) disable iff (rst)
    shifting |=> (addend_o == {$past(addend_o[0]), $past(addend_o[WIDTH-1:1])}));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (idle_o && !start_i && !load_i) |=> ($stable(carry_o) && $stable(acc_o) && $stable(addend_o) && idle_o));

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    $fell(idle_o) |-> $past(start_i && !load_i));
endmodule

bind serial_accum_adder serial_accum_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .load_i(load_i),
  .a_in(a_in), .b_in(b_in), .acc_o(acc_o), .addend_o(addend_o),
  .carry_o(carry_o), .idle_o(idle_o)
);

// File: tb/serial_accum_adder_test.sv
module serial_accum_adder_test;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst, start_i, load_i;
  logic [W-1:0] a_in, b_in, acc_o, addend_o;
  logic carry_o, idle_o;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_accum_adder #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .load_i(load_i),
    .a_in(a_in), .b_in(b_in), .acc_o(acc_o), .addend_o(addend_o),
    .carry_o(carry_o), .idle_o(idle_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_load(input int a, input int b);
    load_i = 1'b1; a_in = W'(a); b_in = W'(b);
    tick();
    load_i = 1'b0;
  endtask

  // one run; extra controls held high through the busy cycles when asked
  task automatic do_run(input bit hold_start, input bit busy_load, input string tag);
    start_i = 1'b1;
    tick();
    start_i = hold_start;
    if (busy_load) begin load_i = 1'b1; a_in = ~a_in; b_in = ~b_in; end
    for (int k = 1; k < W; k++) begin
      check(idle_o == 1'b0, tag, idle_o, 0);
      tick();
    end
    start_i = 1'b0; load_i = 1'b0;
    check(idle_o == 1'b1, tag, idle_o, 1);
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; load_i = 1'b0; a_in = '0; b_in = '0;
    tick(); tick();
    rst = 1'b0;
    // R1 reset state
    check(idle_o && acc_o == 0 && addend_o == 0 && !carry_o, "R1 reset",
          {acc_o, addend_o, carry_o, idle_o}, 1);

    // R11 worked example, with per-shift checks for R4/R5/R6
    do_load(5, 7);
    check(acc_o == 4'b0101 && addend_o == 4'b0111 && !carry_o, "R2 load", {acc_o, addend_o}, 8'h57);
    begin
      int acc, add, c;
      acc = 5; add = 7; c = 0;
      start_i = 1'b1;
      for (int k = 0; k < W; k++) begin
        int s, co;
        s  = (acc & 1) ^ (add & 1) ^ c;
        co = ((acc & 1) + (add & 1) + c) >> 1;
        acc = (acc >> 1) | (s << (W - 1));
        add = (add >> 1) | ((add & 1) << (W - 1));
        c = co;
        tick();
        start_i = 1'b0;
        check(acc_o == W'(acc), "R4 acc shift", acc_o, acc);
        check(addend_o == W'(add), "R5 addend rotate", addend_o, add);
        check(carry_o == c[0], "R6 carry update", carry_o, c);
      end
    end
    check(acc_o == 4'b1100 && !carry_o && idle_o, "R11 example", {carry_o, acc_o}, 12);
    check(addend_o == 4'b0111, "R5 addend restored", addend_o, 7);

    // R6 idle hold then chained run using stored carry
    do_load(9, 8);
    do_run(1'b0, 1'b0, "R3 run length");
    check(carry_o == 1'b1 && acc_o == 4'd1, "R7 9+8", {carry_o, acc_o}, 17);
    tick(); tick();
    check(carry_o == 1'b1 && acc_o == 4'd1 && addend_o == 4'd8, "R6 idle hold",
          {carry_o, acc_o, addend_o}, 9'h118);
    do_run(1'b0, 1'b0, "R3 chained run");
    check({carry_o, acc_o} == 5'(1 + 8 + 1), "R6 stored carry-in", {carry_o, acc_o}, 10);

    // R10 load and start together in idle
    load_i = 1'b1; start_i = 1'b1; a_in = 4'd3; b_in = 4'd12;
    tick();
    load_i = 1'b0; start_i = 1'b0;
    check(idle_o && acc_o == 4'd3 && addend_o == 4'd12 && !carry_o, "R10 load wins",
          {idle_o, acc_o, addend_o}, 9'h13C);
    tick();
    check(idle_o && acc_o == 4'd3, "R10 no shift", {idle_o, acc_o}, 8'h13);

    // R8 / R9 controls held high during a run
    do_load(14, 13);
    do_run(1'b1, 1'b1, "R9 run not lengthened");
    check({carry_o, acc_o} == 5'd27, "R8 busy load ignored", {carry_o, acc_o}, 27);
    check(addend_o == 4'd13, "R9 addend intact", addend_o, 13);

    // R7 exhaustive sweep
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        do_load(a, b);
        do_run(1'b0, 1'b0, "R3 sweep");
        check({carry_o, acc_o} == 5'(a + b), "R7 sum", {carry_o, acc_o}, a + b);
        check(addend_o == W'(b), "R5 sweep restore", addend_o, b);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule